// File: doc/BRIEF.md
# SPI Flash Sector Erase Sequencer

This block erases one sector of an external serial flash with no other help. A host pulses a start strobe and presents a 24-bit byte address. The block then runs the whole erase through its own SPI master in mode 3. The clock idles high, MOSI changes on the falling edge and MISO is sampled on the rising edge. Every word is 8 bits long and leaves most significant bit first.

The erase takes three kinds of frame, and each one has its own chip-select window. The first frame enables writes. The second carries the erase command and the address. After that, status-read frames repeat until the device reports that it is no longer busy. The block's state machine owns the active-low select line; the shift engine never drives it. Between frames the select line stays high for at least one SCLK period, and it only changes while SCLK is high. If the device is still busy after a set number of polls, the block gives up and reports an error.

The SCLK rate comes from the system clock. Each half period lasts `SYS_HZ/(2*SCK_HZ)` system clocks, which is 4 clocks at the default 64 MHz system clock and 8 MHz SCLK.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, ssn_o is 1 and sclk_o is 1.
- R2: SPI mode 3. sclk_o idles high. mosi_o changes only on a falling sclk_o edge. miso_i is sampled on the rising edge. Words are 8 bits, sent MSB first.
- R3: The first frame of a transaction carries exactly one byte, 0x06 (write enable).
- R4: The second frame carries exactly four bytes: 0x20 (sector erase), then address bits [23:16], [15:8] and [7:0], in that order.
- R5: Each later frame carries exactly two bytes: 0x05 (read status), then one byte read back from the device. Polling repeats while bit 0 of the byte read back is 1. Bits 7..1 of that byte are ignored.
- R6: When a poll returns bit 0 equal to 0, busy_o falls and done_o rises. done_o stays high until the next accepted start, which clears it.
- R7: If POLL_MAX polls in a row return bit 0 equal to 1, the block sets err_o, leaves done_o low, returns to idle and sends no further frame.
- R8: Between two frames of one transaction, ssn_o stays high for at least 2*HALF_DIV system clocks. sclk_o is 1 whenever ssn_o changes.
- R9: A start_i pulse while busy_o is high is ignored. The running transaction keeps its latched address, and no extra transaction follows.
- R10: Every low phase of sclk_o lasts exactly HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| addr_i | input | ADDR_W | Byte address of the sector to erase |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Erase finished cleanly (sticky) |
| err_o | output | 1 | Poll limit reached (sticky) |
| sclk_o | output | 1 | SPI clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| ssn_o | output | 1 | Chip select, active low |

## Verification
Two things can happen in the same step: the poll counter reaching its limit, and the busy bit reading back clear. The flash model in the bench holds its busy bit for exactly POLL_MAX-1 polls, so the last allowed poll is also the first one that reads clear. That case must end with done_o set and err_o low. The other collision is a start strobe that arrives in the middle of a transaction. The bench pulses start with a different address during the erase and then checks that the erase frame carries the first address and that the total frame count matches a single transaction.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_XFER, ST_DESEL, ST_GAP} st_e;
  typedef enum logic [1:0] {PH_WREN, PH_ERASE, PH_POLL} ph_e;
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_SE   = 8'h20;
  localparam logic [7:0] CMD_RDSR = 8'h05;
endpackage

// File: rtl/fes_tick.sv
module fes_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fes_shift.sv
module fes_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic       act_q;
  logic [7:0] tx_q;
  logic [2:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      tx_q   <= '0;
      bcnt_q <= '0;
      sclk_o <= 1'b1;
      mosi_o <= 1'b1;
      done_o <= 1'b0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        act_q  <= 1'b1;
        tx_q   <= data_i;
        bcnt_q <= '0;
      end else if (act_q && tick_i) begin
        if (sclk_o) begin
          // falling edge: launch next bit
          sclk_o <= 1'b0;
          mosi_o <= tx_q[7];
        end else begin
          // rising edge: capture
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[6:0], miso_i};
          tx_q   <= {tx_q[6:0], 1'b0};
          if (bcnt_q == 3'd7) begin
            act_q  <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      end
    end
  end

  a_r2_mosi_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> $fell(sclk_o));
  a_r2_byte_ends_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sclk_o);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int SYS_HZ   = 64_000_000,
  parameter int SCK_HZ   = 8_000_000,
  parameter int ADDR_W   = 24,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ssn_o
);
  localparam int HALF_RAW   = SYS_HZ / (2 * SCK_HZ);
  localparam int HALF_DIV   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IW         = $clog2(ADDR_BYTES + 1) + 1;
  localparam int PCW        = $clog2(POLL_MAX + 1);

  st_e               st_q;
  ph_e               ph_q;
  logic [IW-1:0]     idx_q;
  logic              gap_q;
  logic [PCW-1:0]    poll_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_q;
  logic              tick, sh_done;
  logic [7:0]        rx, tx_byte;
  logic              last_byte;
  logic [ADDR_W-1:0] addr_sh;

  fes_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  fes_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(load_q),
    .data_i(tx_byte), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .done_o(sh_done), .rx_o(rx)
  );

  always_comb begin
    addr_sh   = addr_q >> (8 * (ADDR_BYTES - int'(idx_q)));
    tx_byte   = 8'h00;
    last_byte = 1'b1;
    case (ph_q)
      PH_WREN:  begin tx_byte = CMD_WREN; last_byte = (idx_q == '0); end
      PH_ERASE: begin
        tx_byte   = (idx_q == '0) ? CMD_SE : addr_sh[7:0];
        last_byte = (idx_q == IW'(ADDR_BYTES));
      end
      default:  begin
        tx_byte   = (idx_q == '0) ? CMD_RDSR : 8'h00;
        last_byte = (idx_q == IW'(1));
      end
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_WREN;
      idx_q  <= '0;
      gap_q  <= 1'b0;
      poll_q <= '0;
      addr_q <= '0;
      load_q <= 1'b0;
      ssn_o  <= 1'b1;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q <= addr_i;
          ph_q   <= PH_WREN;
          poll_q <= '0;
          done_o <= 1'b0;
          err_o  <= 1'b0;
          ssn_o  <= 1'b0;
          st_q   <= ST_SEL;
        end
        ST_SEL: if (tick) begin
          idx_q  <= '0;
          load_q <= 1'b1;
          st_q   <= ST_XFER;
        end
        ST_XFER: if (sh_done) begin
          if (last_byte) st_q <= ST_DESEL;
          else begin
            idx_q  <= idx_q + 1'b1;
            load_q <= 1'b1;
          end
        end
        ST_DESEL: if (tick) begin
          ssn_o <= 1'b1;
          gap_q <= 1'b0;
          st_q  <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (!gap_q) gap_q <= 1'b1;
          else begin
            case (ph_q)
              PH_WREN:  begin ph_q <= PH_ERASE; ssn_o <= 1'b0; st_q <= ST_SEL; end
              PH_ERASE: begin ph_q <= PH_POLL;  ssn_o <= 1'b0; st_q <= ST_SEL; end
              default: begin
                if (!rx[0]) begin
                  done_o <= 1'b1;
                  st_q   <= ST_IDLE;
                end else if (poll_q == PCW'(POLL_MAX - 1)) begin
                  err_o <= 1'b1;
                  st_q  <= ST_IDLE;
                end else begin
                  poll_q <= poll_q + 1'b1;
                  ssn_o  <= 1'b0;
                  st_q   <= ST_SEL;
                end
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_err_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
  a_r7_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PCW'(POLL_MAX));
  a_r8_ssn_edge_sclk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ssn_o) |-> sclk_o);
  a_r9_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int HALF = 4;
  localparam int PMAX = 4;

  typedef struct packed {
    logic [23:0] addr;
    logic [7:0]  busy;
    logic        exp_err;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{24'h123456, 8'd0, 1'b0},
    '{24'hABCDEF, 8'd2, 1'b0},
    '{24'h000001, 8'd3, 1'b0},
    '{24'hFF00A5, 8'd9, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] addr = '0;
  logic busy, done, err, sclk, mosi, ssn;
  logic miso_r = 1'b1;

  flash_erase_seq #(.POLL_MAX(PMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .err_o(err), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso_r), .ssn_o(ssn)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [7:0] byte_log [0:255];
  int fr_start [0:63];
  int fr_len   [0:63];
  int nbytes = 0, nframes = 0, bitn = 0, busy_left = 0, edge_bad = 0;
  logic in_frame = 1'b0;
  logic [7:0]  rsr = '0;
  logic [15:0] out_sr = '0;
  int lo_run = 0, lo_bad = 0, hi_run = 0, falls = 0, gap_min = 1 << 20;
  logic ssn_prev = 1'b1;

  // flash model
  always @(negedge ssn) begin
    if (sclk !== 1'b1) edge_bad++;
    in_frame = 1'b1;
    if (nframes < 64) fr_start[nframes] = nbytes;
    bitn   = 0;
    out_sr = {8'h00, (busy_left > 0) ? 8'h01 : 8'hFE};
  end
  always @(posedge ssn) begin
    if (in_frame) begin
      if (sclk !== 1'b1) edge_bad++;
      in_frame = 1'b0;
      if (nframes < 64) begin
        fr_len[nframes] = nbytes - fr_start[nframes];
        if (byte_log[fr_start[nframes]] == 8'h05 && busy_left > 0) busy_left--;
      end
      nframes++;
    end
  end
  always @(posedge sclk) if (ssn === 1'b0) begin
    rsr = {rsr[6:0], mosi};
    bitn++;
    if (bitn == 8) begin
      if (nbytes < 256) byte_log[nbytes] = rsr;
      nbytes++;
      bitn = 0;
    end
  end
  always @(negedge sclk) if (ssn === 1'b0) begin
    miso_r = out_sr[15];
    out_sr = out_sr << 1;
  end

  // timing monitors
  always @(posedge clk) if (rst_n) begin
    if (sclk === 1'b0) lo_run++;
    else if (lo_run > 0) begin
      if (lo_run != HALF) lo_bad++;
      lo_run = 0;
    end
    if (ssn === 1'b1) hi_run++;
    else if (ssn_prev === 1'b1) begin
      if (falls > 0 && hi_run < gap_min) gap_min = hi_run;
      falls++;
      hi_run = 0;
    end
    ssn_prev = ssn;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    nbytes = 0; nframes = 0; edge_bad = 0; lo_bad = 0; falls = 0;
    gap_min = 1 << 20;
    for (int i = 0; i < 256; i++) byte_log[i] = 8'h00;
  endtask

  task automatic pulse_start(input logic [23:0] a);
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100000) begin @(negedge clk); n++; end
    if (busy) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=busy expected=idle");
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_txn(input logic [23:0] a, input int polls, input logic eerr);
    int bad = 0;
    check("R3 frame0 len", fr_len[0], 1);
    check("R3 frame0 byte", byte_log[fr_start[0]], 8'h06);
    check("R4 frame1 len", fr_len[1], 4);
    check("R4 frame1 cmd", byte_log[fr_start[1]], 8'h20);
    check("R2 msb-first addr hi", byte_log[fr_start[1] + 1], a[23:16]);
    check("R4 addr bytes", {byte_log[fr_start[1] + 2], byte_log[fr_start[1] + 3]}, a[15:0]);
    check("R5 frame count", nframes, 2 + polls);
    for (int f = 2; f < nframes && f < 64; f++)
      if (fr_len[f] != 2 || byte_log[fr_start[f]] != 8'h05) bad++;
    check("R5 poll frames", bad, 0);
    check("R6 done", done, !eerr);
    check("R7 err", err, eerr);
    check("R6 busy low", busy, 0);
    check("R8 sclk high at ssn edges", edge_bad, 0);
    check("R8 min gap ok", gap_min >= 2 * HALF, 1);
    check("R10 sclk low phase", lo_bad, 0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 ssn", ssn, 1);
    check("R1 sclk", sclk, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      int polls;
      clear_logs();
      busy_left = VECS[v].busy;
      polls = VECS[v].exp_err ? PMAX : VECS[v].busy + 1;
      pulse_start(VECS[v].addr);
      check("R6 busy after start", busy, 1);
      check("R6 done cleared on start", done, 0);
      wait_idle();
      check_txn(VECS[v].addr, polls, VECS[v].exp_err);
    end

    // R6 done held while idle
    clear_logs();
    busy_left = 0;
    pulse_start(24'h00C0DE);
    wait_idle();
    repeat (50) @(negedge clk);
    check("R6 done held", done, 1);
    check("R6 no stray frames", nframes, 3);

    // R9 start while busy ignored
    clear_logs();
    busy_left = 1;
    pulse_start(24'h5A5A5A);
    repeat (300) @(negedge clk);
    pulse_start(24'h0F0F0F);
    wait_idle();
    check_txn(24'h5A5A5A, 2, 1'b0);
    repeat (200) @(negedge clk);
    check("R9 single transaction", nframes, 4);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule